// File: doc/BRIEF.md
# Wake Event and PHY Reset Controller

This block collects the power-management wake sources of a network controller and reports them two ways. A wakeup pulse from the MAC (magic packet or wakeup frame match) and an interrupt from the PHY (link change or energy detect) are each gated by their own enable. A gated event sets a sticky status bit and a shared PME status flag. The block drives an active-low power-management event pin towards the host, qualified by a PME enable. It also raises a wake interrupt towards the local interrupt controller.

The block also watches the power-state sequencer. When the sequencer reports a transition, a fixed table looks at the transition code, the auxiliary-power-detect level and the PME enable. From these it decides whether the PHY must be reset, and whether it comes out of reset in normal mode (all-capable, auto-negotiation on) or in general power-down. The PHY applies its own rule that a soft reset leaves its sticky register bits untouched. The reset request here carries only the mode.

Top module: `wake_phyrst_ctrl`

## Requirements
- R1: A rising edge on `mac_wake_i` sets `wake_sts_o[1]` only while `wol_en_i` is 1. Counting the first rising clock edge that samples the input high as edge one, the bit is visible after edge three.
- R2: A rising edge on `phy_irq_i` sets `wake_sts_o[0]` only while `ed_en_i` is 1, with the same three-edge latency as R1.
- R3: An event input held high sets its status bit once only. After that bit is cleared, it stays clear while the input remains high.
- R4: Each status bit is sticky and is cleared by a one-cycle 1 on the matching bit of `clr_wake_i`. If a set and a clear meet in the same cycle, the bit stays set.
- R5: `pme_sts_o` is set by any gated wake event and is cleared by `clr_pme_i`. A set in the same cycle as a clear wins.
- R6: `pme_n_o` is 0 exactly when `pme_sts_o` is 1 and `pme_en_i` was 1 at the previous edge. A change of `pme_en_i` reaches the pin after one edge.
- R7: `wake_irq_o` is 1 exactly while at least one `wake_sts_o` bit is 1.
- R8: When `trans_valid_i` is 1 at an edge, `phy_rst_o` is 1 for exactly the next cycle in these cases. Code 9 with aux low selects normal. Code 6 with aux high selects power-down. Codes 1 or 3 with PME enable 0 select power-down. Codes 10 or 11 with aux high and PME enable 0 select power-down. Code 5 with PME enable 0 selects normal. The selected mode appears on `phy_pwrdn_o` in the same cycle as the pulse, with 1 meaning general power-down.
- R9: Any other code and condition combination, or `trans_valid_i` low, gives no pulse and leaves `phy_pwrdn_o` unchanged.
- R10: After a synchronous reset, status bits, PME status, interrupt, reset pulse and `phy_pwrdn_o` are 0, and `pme_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mac_wake_i | input | 1 | MAC wakeup event, asynchronous |
| phy_irq_i | input | 1 | PHY interrupt, asynchronous |
| wol_en_i | input | 1 | Enable for the MAC wake source |
| ed_en_i | input | 1 | Enable for the PHY wake source |
| pme_en_i | input | 1 | PME enable |
| aux_pwr_i | input | 1 | Auxiliary power detected |
| clr_wake_i | input | 2 | Write-1 clear of the wake status bits |
| clr_pme_i | input | 1 | Write-1 clear of PME status |
| trans_valid_i | input | 1 | Power-state transition strobe |
| trans_code_i | input | 4 | Transition number |
| wake_sts_o | output | 2 | Sticky status: bit 1 MAC, bit 0 PHY |
| pme_sts_o | output | 1 | Sticky PME status |
| pme_n_o | output | 1 | Active-low power-management event |
| wake_irq_o | output | 1 | Wake interrupt request |
| phy_rst_o | output | 1 | One-cycle PHY reset request |
| phy_pwrdn_o | output | 1 | PHY mode after reset, 1 = power-down |

## Verification
A fresh wake event and a software clear of the same status bit can land on one clock edge. The bench provokes this by raising the PHY interrupt while its bit is already set, then asserting the matching clear and the PME clear at the edge where the synchronised edge reaches the status register. Both the status bit and PME status must read 1 afterwards. A clear aimed at the other bit in that same cycle must still take effect.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int unsigned TR_W = 4;

  typedef enum logic {
    PHY_NORMAL = 1'b0,
    PHY_PWRDN  = 1'b1
  } phy_mode_e;

  localparam logic [TR_W-1:0] TR_1  = 4'd1;
  localparam logic [TR_W-1:0] TR_3  = 4'd3;
  localparam logic [TR_W-1:0] TR_5  = 4'd5;
  localparam logic [TR_W-1:0] TR_6  = 4'd6;
  localparam logic [TR_W-1:0] TR_9  = 4'd9;
  localparam logic [TR_W-1:0] TR_10 = 4'd10;
  localparam logic [TR_W-1:0] TR_11 = 4'd11;
endpackage

// File: rtl/wk_sync_edge.sv
module wk_sync_edge #(
  parameter int unsigned N      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] chain [STAGES];
  logic [N-1:0] prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else if (s == 0) chain[s] <= async_i;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else prev_q <= chain[STAGES-1];
  end

  assign rise_o = chain[STAGES-1] & ~prev_q;

  generate
    for (genvar b = 0; b < N; b++) begin : g_chk
      // R3
      rise_once_chk: assert property (@(posedge clk) disable iff (rst)
        rise_o[b] |=> !rise_o[b]);
    end
  endgenerate
endmodule

// File: rtl/wk_sticky.sv
module wk_sticky #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         clr_pme_i,
  output logic [N-1:0] sts_q,
  output logic [N-1:0] sts_d,
  output logic         pme_q,
  output logic         pme_d
);
  always_comb begin
    sts_d = (sts_q & ~clr_i) | set_i;
    pme_d = (pme_q & ~clr_pme_i) | (|set_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q <= '0;
      pme_q <= 1'b0;
    end else begin
      sts_q <= sts_d;
      pme_q <= pme_d;
    end
  end

  generate
    for (genvar b = 0; b < N; b++) begin : g_chk
      // R4
      set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set_i[b] |=> sts_q[b]);
      // R4
      clr_takes_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i[b] && !set_i[b]) |=> !sts_q[b]);
    end
  endgenerate
  // R5
  pme_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (|set_i) |=> pme_q);
endmodule

// File: rtl/wk_phy_decode.sv
module wk_phy_decode
  import wake_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            valid_i,
  input  logic [TR_W-1:0] code_i,
  input  logic            aux_i,
  input  logic            pme_en_i,
  output logic            rst_o,
  output phy_mode_e       mode_o
);
  logic      hit;
  phy_mode_e sel;

  always_comb begin
    hit = 1'b0;
    sel = PHY_NORMAL;
    if (valid_i) begin
      case (code_i)
        TR_9:  if (!aux_i) begin hit = 1'b1; sel = PHY_NORMAL; end
        TR_6:  if (aux_i)  begin hit = 1'b1; sel = PHY_PWRDN;  end
        TR_1, TR_3:
               if (!pme_en_i) begin hit = 1'b1; sel = PHY_PWRDN; end
        TR_10, TR_11:
               if (aux_i && !pme_en_i) begin hit = 1'b1; sel = PHY_PWRDN; end
        TR_5:  if (!pme_en_i) begin hit = 1'b1; sel = PHY_NORMAL; end
        default: hit = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_o  <= 1'b0;
      mode_o <= PHY_NORMAL;
    end else begin
      rst_o <= hit;
      if (hit) mode_o <= sel;
    end
  end

  // R8
  rst_single_chk: assert property (@(posedge clk) disable iff (rst)
    rst_o |=> !rst_o);
  // R9
  no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> !rst_o);
  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> $stable(mode_o));
endmodule

// File: rtl/wake_phyrst_ctrl.sv
module wake_phyrst_ctrl
  import wake_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mac_wake_i,
  input  logic            phy_irq_i,
  input  logic            wol_en_i,
  input  logic            ed_en_i,
  input  logic            pme_en_i,
  input  logic            aux_pwr_i,
  input  logic [1:0]      clr_wake_i,
  input  logic            clr_pme_i,
  input  logic            trans_valid_i,
  input  logic [TR_W-1:0] trans_code_i,
  output logic [1:0]      wake_sts_o,
  output logic            pme_sts_o,
  output logic            pme_n_o,
  output logic            wake_irq_o,
  output logic            phy_rst_o,
  output logic            phy_pwrdn_o
);
  localparam int unsigned NSRC = 2;

  logic [NSRC-1:0] rise, gated, sts_d;
  logic            pme_d;
  phy_mode_e       mode;

  wk_sync_edge #(.N(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .async_i({mac_wake_i, phy_irq_i}),
    .rise_o(rise)
  );

  assign gated = rise & {wol_en_i, ed_en_i};

  wk_sticky #(.N(NSRC)) u_sticky (
    .clk(clk), .rst(rst),
    .set_i(gated), .clr_i(clr_wake_i), .clr_pme_i(clr_pme_i),
    .sts_q(wake_sts_o), .sts_d(sts_d),
    .pme_q(pme_sts_o), .pme_d(pme_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pme_n_o    <= 1'b1;
      wake_irq_o <= 1'b0;
    end else begin
      pme_n_o    <= ~(pme_d & pme_en_i);
      wake_irq_o <= |sts_d;
    end
  end

  wk_phy_decode u_dec (
    .clk(clk), .rst(rst),
    .valid_i(trans_valid_i), .code_i(trans_code_i),
    .aux_i(aux_pwr_i), .pme_en_i(pme_en_i),
    .rst_o(phy_rst_o), .mode_o(mode)
  );

  assign phy_pwrdn_o = (mode == PHY_PWRDN);

  // R6
  pme_pin_chk: assert property (@(posedge clk) disable iff (rst)
    !pme_n_o |-> pme_sts_o);
  // R7
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    wake_irq_o == (|wake_sts_o));
endmodule

// File: tb/test_wake_phyrst_ctrl.sv
module test_wake_phyrst_ctrl;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mac_wake_i = 0, phy_irq_i = 0, wol_en_i = 0, ed_en_i = 0;
  logic pme_en_i = 1, aux_pwr_i = 0, clr_pme_i = 0, trans_valid_i = 0;
  logic [1:0] clr_wake_i = '0;
  logic [3:0] trans_code_i = '0;
  logic [1:0] wake_sts_o;
  logic pme_sts_o, pme_n_o, wake_irq_o, phy_rst_o, phy_pwrdn_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_phyrst_ctrl i_wake_phyrst_ctrl (
    .clk(clk), .rst(rst), .mac_wake_i(mac_wake_i), .phy_irq_i(phy_irq_i),
    .wol_en_i(wol_en_i), .ed_en_i(ed_en_i), .pme_en_i(pme_en_i),
    .aux_pwr_i(aux_pwr_i), .clr_wake_i(clr_wake_i), .clr_pme_i(clr_pme_i),
    .trans_valid_i(trans_valid_i), .trans_code_i(trans_code_i),
    .wake_sts_o(wake_sts_o), .pme_sts_o(pme_sts_o), .pme_n_o(pme_n_o),
    .wake_irq_o(wake_irq_o), .phy_rst_o(phy_rst_o), .phy_pwrdn_o(phy_pwrdn_o)
  );

  typedef struct {
    logic [6:0] exp;
    string      req;
  } item_t;

  item_t q[$];
  event  go;
  int    errors = 0, checks = 0;
  bit    done = 0;
  logic [1:0] m_sts = '0;
  logic m_pme = 0, m_mode = 0;

  wire [6:0] obs = {wake_sts_o, pme_sts_o, pme_n_o, wake_irq_o, phy_rst_o, phy_pwrdn_o};

  function automatic logic [6:0] mk(logic [1:0] s, logic p, logic pe, logic r, logic m);
    return {s, p, ~(p & pe), |s, r, m};
  endfunction

  task automatic expect_now(input logic [6:0] e, input string r);
    q.push_back('{e, r});
    -> go;
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(go);
      while (q.size() > 0) begin
        it = q.pop_front();
        checks++;
        if (obs !== it.exp) begin
          errors++;
          $display("FAIL %s: got %b expected %b", it.req, obs, it.exp);
        end
      end
    end
  end

  task automatic state_chk(input string r);
    expect_now(mk(m_sts, m_pme, pme_en_i, 1'b0, m_mode), r);
  endtask

  task automatic pulse_src(input bit mac);
    @(negedge clk);
    if (mac) mac_wake_i = 1; else phy_irq_i = 1;
    repeat (3) @(negedge clk);
    mac_wake_i = 0; phy_irq_i = 0;
  endtask

  task automatic clear(input logic [1:0] w, input logic p);
    @(negedge clk);
    clr_wake_i = w; clr_pme_i = p;
    @(negedge clk);
    clr_wake_i = '0; clr_pme_i = 0;
  endtask

  task automatic trans(input logic [3:0] code, input logic aux, input logic pe,
                       input logic hit, input logic mode, input string r);
    @(negedge clk);
    aux_pwr_i = aux; pme_en_i = pe;
    trans_valid_i = 1; trans_code_i = code;
    @(negedge clk);
    trans_valid_i = 0;
    if (hit) m_mode = mode;
    expect_now(mk(m_sts, m_pme, pe, hit, m_mode), r);
    @(negedge clk);
    expect_now(mk(m_sts, m_pme, pe, 1'b0, m_mode), r);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst = 0;
    state_chk("R10 reset state");

    wol_en_i = 1;
    pulse_src(1);
    m_sts = 2'b10; m_pme = 1;
    state_chk("R1 mac wake enabled");

    pulse_src(0);
    state_chk("R2 phy irq disabled ignored");

    clear(2'b10, 1);
    m_sts = 2'b00; m_pme = 0;
    state_chk("R4 R5 write-1 clear");

    wol_en_i = 0;
    pulse_src(1);
    state_chk("R1 mac wake disabled ignored");

    ed_en_i = 1;
    pulse_src(0);
    m_sts = 2'b01; m_pme = 1;
    state_chk("R2 R7 phy irq enabled");

    @(negedge clk); pme_en_i = 0;
    @(negedge clk);
    state_chk("R6 pme enable off releases pin");
    pme_en_i = 1;
    @(negedge clk);
    state_chk("R6 pme enable on drives pin");

    // R4 R5 coincident set and clear
    @(negedge clk); phy_irq_i = 1;
    repeat (2) @(negedge clk);
    clr_wake_i = 2'b01; clr_pme_i = 1;
    @(negedge clk);
    clr_wake_i = '0; clr_pme_i = 0; phy_irq_i = 0;
    state_chk("R4 R5 set wins over clear");

    wol_en_i = 1;
    pulse_src(1);
    m_sts = 2'b11;
    @(negedge clk); phy_irq_i = 1;
    repeat (2) @(negedge clk);
    clr_wake_i = 2'b11;
    @(negedge clk);
    clr_wake_i = '0; phy_irq_i = 0;
    m_sts = 2'b01;
    state_chk("R4 other bit cleared in same cycle");

    clear(2'b11, 1);
    m_sts = 2'b00; m_pme = 0;
    state_chk("R4 all cleared");

    // R3 held input
    @(negedge clk); mac_wake_i = 1;
    repeat (3) @(negedge clk);
    m_sts = 2'b10; m_pme = 1;
    state_chk("R3 held input sets once");
    clear(2'b10, 1);
    repeat (4) @(negedge clk);
    m_sts = 2'b00; m_pme = 0;
    state_chk("R3 no re-set while held");
    mac_wake_i = 0;
    repeat (4) @(negedge clk);
    state_chk("R3 release quiet");

    trans(4'd9,  0, 1, 1, 0, "R8 T9 aux low normal");
    trans(4'd6,  1, 1, 1, 1, "R8 T6 aux high power-down");
    trans(4'd9,  1, 1, 0, 0, "R9 T9 aux high no reset");
    trans(4'd5,  1, 0, 1, 0, "R8 T5 pme off normal");
    trans(4'd1,  1, 0, 1, 1, "R8 T1 pme off power-down");
    trans(4'd5,  0, 1, 0, 0, "R9 T5 pme on no reset");
    trans(4'd3,  0, 1, 0, 0, "R9 T3 pme on no reset");
    trans(4'd3,  0, 0, 1, 1, "R8 T3 pme off power-down");
    trans(4'd9,  0, 0, 1, 0, "R8 T9 pme don't-care");
    trans(4'd10, 1, 0, 1, 1, "R8 T10 aux high pme off");
    trans(4'd11, 0, 0, 0, 0, "R9 T11 aux low no reset");
    trans(4'd11, 1, 1, 0, 0, "R9 T11 pme on no reset");
    trans(4'd7,  1, 0, 0, 0, "R9 unlisted code");
    trans(4'd5,  0, 0, 1, 0, "R8 T5 back to normal");
    trans(4'd11, 1, 0, 1, 1, "R8 T11 aux high pme off");

    @(negedge clk);
    #1;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule